// File: doc/BRIEF.md
# Two-Tier Overcurrent Hiccup Controller

This block guards the discharge path of a battery pack against sustained overload and hard short circuits. Two comparator flags report the pack discharge current: one asserts above a moderate overload level (about 150 mV across the sense shunt, near 6 A with a 25 milliohm shunt), the other above a short-circuit level (about 375 mV, near 15 A). Each flag has its own blanking window, given as a count of timing ticks. Surge currents shorter than the window are tolerated, for example when a large filter capacitor on the load charges.

When a flag stays asserted for its whole window, the block opens the discharge switch. It holds the switch open for an off period of seventeen times the overload blanking window, then closes it and starts blanking again from zero. While the fault persists, this produces a hiccup pattern of roughly 6 % on-time for the overload tier and far less for the short-circuit tier. When the fault is gone, the switch stays closed and no intervention is needed. A free-running tick input paces all timing. A status output records which tier caused the latest trip.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: With `ovc_lo_i` high on `blank_lo_i` consecutive tick cycles, `dsg_en_o` goes low right after the clock edge of the last of those ticks, and `trip_src_o` becomes 2'b01 (overload tier).
- R2: If `ovc_lo_i` (or `ovc_hi_i`) is low in any cycle before its window completes, that tier's tick count restarts from zero, so a later burst again needs a full window to trip.
- R3: The short-circuit tier counts independently. `ovc_hi_i` high on `blank_hi_i` consecutive ticks trips even when the overload count has not reached its limit, and `trip_src_o` becomes 2'b10.
- R4: After a trip from either tier, `dsg_en_o` stays low for exactly 17 × `blank_lo_i` ticks, counted from the first tick after the trip. It returns high right after the edge of the last of them.
- R5: During the off period, both blanking counts are held at zero whatever the comparators show. After the restart, a full window is needed again.
- R6: While the overcurrent persists, trip and off period repeat indefinitely.
- R7: Once both comparators are low, `dsg_en_o` remains high after the restart.
- R8: If both tiers complete their windows on the same tick, the trip is recorded as short-circuit (2'b10).
- R9: Only cycles with `tick_i` high advance a blanking count. A comparator held high with no ticks never trips.
- R10: After reset, `dsg_en_o` is 1 and `trip_src_o` is 2'b00. `trip_src_o` keeps the cause of the latest trip until the next trip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timing pulse that paces all windows |
| ovc_lo_i | input | 1 | Overload comparator, current above tier-1 level |
| ovc_hi_i | input | 1 | Short-circuit comparator, current above tier-2 level |
| blank_lo_i | input | CNT_W | Tier-1 blanking window in ticks; also sets the off period |
| blank_hi_i | input | CNT_W | Tier-2 blanking window in ticks |
| dsg_en_o | output | 1 | Discharge switch enable, 1 = switch closed |
| trip_src_o | output | 2 | Cause of latest trip: 00 none, 01 overload, 10 short circuit |

## Verification
The properties assume that both window inputs are at least one and are changed only while the switch is closed and neither comparator is high. The off-period length check compares against the current `blank_lo_i`. The stimulus sets the windows during reset and changes the short-circuit window once, with both comparators low and the switch closed. Ticks are single-cycle pulses separated by an idle cycle, so a decision always follows one identifiable tick edge.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_OFF = 1'b1
    } ocp_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_T1   = 2'b01,
        SRC_T2   = 2'b10
    } trip_src_e;

    typedef struct packed {
        ocp_state_e st;
        trip_src_e  src;
        logic       dsg;
    } ocp_ctl_t;

endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             trip_i,
    input  logic [CNT_W-1:0] blank_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   nxt;

    always_comb begin
        nxt      = {1'b0, cnt_q} + 1'b1;
        expire_o = en_i && trip_i && tick_i && (nxt >= {1'b0, blank_i});
        cnt_d    = cnt_q;
        if (!en_i || !trip_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = expire_o ? '0 : nxt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ocp_off_timer.sv
module ocp_off_timer #(
    parameter int CNT_W    = 16,
    parameter int OFF_MULT = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] blank_i,
    output logic             done_o
);
    localparam int LIM_W = CNT_W + $clog2(OFF_MULT + 1);

    logic [LIM_W-1:0] limit, cnt_d, cnt_q;
    logic [LIM_W:0]   nxt;

    always_comb begin
        limit  = LIM_W'(blank_i) * LIM_W'(OFF_MULT);
        nxt    = {1'b0, cnt_q} + 1'b1;
        done_o = en_i && tick_i && (nxt >= {1'b0, limit});
        cnt_d  = cnt_q;
        if (!en_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = done_o ? '0 : nxt[LIM_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
    import ocp_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int OFF_MULT = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ovc_lo_i,
    input  logic             ovc_hi_i,
    input  logic [CNT_W-1:0] blank_lo_i,
    input  logic [CNT_W-1:0] blank_hi_i,
    output logic             dsg_en_o,
    output logic [1:0]       trip_src_o
);
    localparam int TIERS = 2;

    ocp_ctl_t         ctl_d, ctl_q;
    logic [TIERS-1:0] trip_v, exp_v;
    logic [CNT_W-1:0] blank_v [TIERS];
    logic             run_en, off_done;

    assign trip_v     = {ovc_hi_i, ovc_lo_i};
    assign blank_v[0] = blank_lo_i;
    assign blank_v[1] = blank_hi_i;
    assign run_en     = (ctl_q.st == ST_RUN);

    for (genvar g = 0; g < TIERS; g++) begin : g_tier
        ocp_blank_timer #(.CNT_W(CNT_W)) u_blank (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (run_en),
            .tick_i   (tick_i),
            .trip_i   (trip_v[g]),
            .blank_i  (blank_v[g]),
            .expire_o (exp_v[g])
        );
    end

    ocp_off_timer #(.CNT_W(CNT_W), .OFF_MULT(OFF_MULT)) u_off (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (!run_en),
        .tick_i  (tick_i),
        .blank_i (blank_lo_i),
        .done_o  (off_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_RUN: begin
                if (exp_v[1]) begin
                    ctl_d.st  = ST_OFF;
                    ctl_d.src = SRC_T2;
                    ctl_d.dsg = 1'b0;
                end else if (exp_v[0]) begin
                    ctl_d.st  = ST_OFF;
                    ctl_d.src = SRC_T1;
                    ctl_d.dsg = 1'b0;
                end
            end
            ST_OFF: begin
                if (off_done) begin
                    ctl_d.st  = ST_RUN;
                    ctl_d.dsg = 1'b1;
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_RUN;
            ctl_q.src <= SRC_NONE;
            ctl_q.dsg <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dsg_en_o   = ctl_q.dsg;
    assign trip_src_o = ctl_q.src;
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk #(
    parameter int CNT_W    = 16,
    parameter int OFF_MULT = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic [CNT_W-1:0] blank_lo_i,
    input logic             dsg_en_o,
    input logic [1:0]       trip_src_o
);
    localparam int LIM_W = CNT_W + $clog2(OFF_MULT + 1);

    logic [LIM_W-1:0] off_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        off_ticks <= '0;
        else if (dsg_en_o) off_ticks <= '0;
        else if (tick_i)   off_ticks <= off_ticks + 1'b1;
    end

    // R1: the switch opens only on a tick edge and always with a recorded cause
    a_r1_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsg_en_o) |-> ($past(tick_i) && trip_src_o != 2'b00));

    // R9: no tick, no change of the switch
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(dsg_en_o));

    // R4: off period equals OFF_MULT windows of tier 1
    a_r4_off_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsg_en_o) |-> (off_ticks == LIM_W'(blank_lo_i) * LIM_W'(OFF_MULT)));

    // R10: the cause code is a legal one-hot-or-zero value
    a_r10_src_code: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trip_src_o));

    // R10: the cause is held while the switch stays closed
    a_r10_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dsg_en_o && $past(dsg_en_o)) |-> $stable(trip_src_o));
endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk #(.CNT_W(CNT_W), .OFF_MULT(OFF_MULT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .blank_lo_i (blank_lo_i),
    .dsg_en_o   (dsg_en_o),
    .trip_src_o (trip_src_o)
);

// File: tb/ocp_hiccup_ctrl_tb.sv
module ocp_hiccup_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int B1         = 3;
    localparam int OFF_TICKS  = 17 * B1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             ovc_lo_i = 1'b0;
    logic             ovc_hi_i = 1'b0;
    logic [CNT_W-1:0] blank_lo_i = CNT_W'(B1);
    logic [CNT_W-1:0] blank_hi_i = CNT_W'(3);
    logic             dsg_en_o;
    logic [1:0]       trip_src_o;

    typedef struct {
        int         cyc;
        logic       dsg;
        logic [1:0] src;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ocp_hiccup_ctrl #(.CNT_W(CNT_W), .OFF_MULT(17)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .ovc_lo_i   (ovc_lo_i),
        .ovc_hi_i   (ovc_hi_i),
        .blank_lo_i (blank_lo_i),
        .blank_hi_i (blank_hi_i),
        .dsg_en_o   (dsg_en_o),
        .trip_src_o (trip_src_o)
    );

    // monitor: pops expectations due at this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (dsg_en_o !== e.dsg || trip_src_o !== e.src) begin
                errors++;
                $display("FAIL %s: dsg=%0b src=%b expected dsg=%0b src=%b",
                         e.tag, dsg_en_o, trip_src_o, e.dsg, e.src);
            end
        end
    end

    task automatic expect_now(input logic d, input logic [1:0] s, input string tag);
        exp_t e;
        e.cyc = cyc; e.dsg = d; e.src = s; e.tag = tag;
        q.push_back(e);
    endtask

    // one tick with given comparator levels; result checked after the tick edge
    task automatic pulse(input bit lo, input bit hi, input logic d,
                         input logic [1:0] s, input string tag);
        exp_t e;
        @(negedge clk);
        ovc_lo_i = lo; ovc_hi_i = hi; tick_i = 1'b1;
        e.cyc = cyc + 1; e.dsg = d; e.src = s; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic idle(input bit lo, input bit hi, input int n,
                        input logic d, input logic [1:0] s, input string tag);
        exp_t e;
        @(negedge clk);
        ovc_lo_i = lo; ovc_hi_i = hi; tick_i = 1'b0;
        repeat (n) @(negedge clk);
        e.cyc = cyc; e.dsg = d; e.src = s; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        expect_now(1'b1, 2'b00, "R10 reset state");

        // R2: interrupted bursts never accumulate to a trip
        pulse(1, 0, 1'b1, 2'b00, "R2 burst a1");
        pulse(1, 0, 1'b1, 2'b00, "R2 burst a2");
        idle(0, 0, 1, 1'b1, 2'b00, "R2 drop");
        pulse(1, 0, 1'b1, 2'b00, "R2 count restarted b1");
        pulse(1, 0, 1'b1, 2'b00, "R2 count restarted b2");
        idle(0, 0, 1, 1'b1, 2'b00, "R2 drop again");

        // R9: comparator high without ticks
        idle(1, 0, 40, 1'b1, 2'b00, "R9 no ticks no trip");
        idle(0, 0, 1, 1'b1, 2'b00, "R9 release");

        // R1: overload trip on the B1-th tick
        pulse(1, 0, 1'b1, 2'b00, "R1 tick1");
        pulse(1, 0, 1'b1, 2'b00, "R1 tick2");
        pulse(1, 0, 1'b0, 2'b01, "R1 trip");

        // R4/R5: off period with comparator still high
        for (int i = 1; i < OFF_TICKS; i++) pulse(1, 0, 1'b0, 2'b01, "R4 off hold");
        pulse(1, 0, 1'b1, 2'b01, "R4 restart");
        pulse(1, 0, 1'b1, 2'b01, "R5 blanking from zero t1");
        pulse(1, 0, 1'b1, 2'b01, "R5 blanking from zero t2");
        pulse(1, 0, 1'b0, 2'b01, "R6 hiccup repeats");

        // R7: fault gone during off period
        for (int i = 1; i < OFF_TICKS; i++) pulse(0, 0, 1'b0, 2'b01, "R4 off hold 2");
        pulse(0, 0, 1'b1, 2'b01, "R4 restart 2");
        for (int i = 0; i < 5; i++) pulse(0, 0, 1'b1, 2'b01, "R7 stays on");

        // R8: both windows equal (3), both expire on the same tick
        pulse(1, 1, 1'b1, 2'b01, "R8 t1");
        pulse(1, 1, 1'b1, 2'b01, "R8 t2");
        pulse(1, 1, 1'b0, 2'b10, "R8 short tier wins");
        for (int i = 1; i < OFF_TICKS; i++) pulse(0, 0, 1'b0, 2'b10, "R4 off tier2");
        pulse(0, 0, 1'b1, 2'b10, "R4 restart tier2");

        // R10: cause updates to the latest trip
        pulse(1, 0, 1'b1, 2'b10, "R10 t1");
        pulse(1, 0, 1'b1, 2'b10, "R10 t2");
        pulse(1, 0, 1'b0, 2'b01, "R10 latest cause overload");
        for (int i = 1; i < OFF_TICKS; i++) pulse(0, 0, 1'b0, 2'b01, "R4 off 3");
        pulse(0, 0, 1'b1, 2'b01, "R4 restart 3");

        // R3: short window 2 trips before overload window 3
        idle(0, 0, 1, 1'b1, 2'b01, "R3 idle");
        blank_hi_i = CNT_W'(2);
        pulse(1, 1, 1'b1, 2'b01, "R3 t1");
        pulse(1, 1, 1'b0, 2'b10, "R3 short tier trips first");
        for (int i = 1; i < OFF_TICKS; i++) pulse(0, 0, 1'b0, 2'b10, "R4 off 4");
        pulse(0, 0, 1'b1, 2'b10, "R4 restart 4");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule